// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register storage for a small processor core with several privilege and exception modes. It maps each register number, together with the current mode, onto physical storage. Registers 0 to 7 and the program counter (register 15) are one copy seen by every mode. The stack pointer (register 13) and the link register (register 14) have one base copy for the unprivileged and system modes, plus a private copy for each of the five exception modes. The same register number therefore reaches different flops depending on the mode input.

The file has two combinational read ports and one write port for general registers. A current status word has its own read and write port. Each exception mode has its own saved status word, which is reached through a separate port that follows the mode. In modes that have no saved status, a read of the saved status returns the current status. A write there is dropped and flagged. Decoding instructions and sequencing mode switches are done by the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0 to 7 are one physical set. A value written in any mode reads back the same in every other mode.
- R2: Registers 13 and 14 have separate copies for the fast-interrupt, interrupt, supervisor, abort and undefined modes. A write in one of these modes is not visible in any other mode.
- R3: User mode and system mode share the base copies of registers 13 and 14.
- R4: Register 15 is a single register that every mode shares.
- R5: The mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other 5-bit code behaves exactly like user mode.
- R6: The current status word is one register. Its write port updates it on the next clock edge, and its read port shows it in every mode.
- R7: Each of the five exception modes has its own saved status word. Reads and writes on the saved-status port reach the copy of the present mode.
- R8: In user or system mode, a read of the saved-status port returns the current status word.
- R9: In user or system mode, a saved-status write changes no stored word. In the cycle after such a write, the error output is 1 for exactly one cycle. It is 0 at all other times.
- R10: When a read and a write hit the same register in the same cycle, the read returns the old value. The new value is visible from the next cycle.
- R11: Register numbers 8 to 12 always read as zero, and writes to them are ignored.
- R12: After reset, all general registers and saved status words read zero. The current status word reads 0x000000D3 (supervisor mode code with bits 7 and 6, the interrupt masks, set). The error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_addr_i | input | 4 | General register write number |
| wr_data_i | input | 32 | General register write data |
| cur_wr_en_i | input | 1 | Current status write enable |
| cur_wr_data_i | input | 32 | Current status write data |
| cur_rd_data_o | output | 32 | Current status word |
| sav_wr_en_i | input | 1 | Saved status write enable |
| sav_wr_data_i | input | 32 | Saved status write data |
| sav_rd_data_o | output | 32 | Saved status word of the present mode |
| sav_err_o | output | 1 | One-cycle flag for a rejected saved-status write |

## Verification
Two pairs of functions can fall in the same cycle. A register write can coincide with a read of the same physical copy. A saved-status write in user or system mode can coincide with a read of the saved-status port, which in those modes shows the current status. The bench provokes both: random cycles mix writes and reads over a small address and mode space, and directed steps place a write and a read on one register in one cycle. A reference model, updated only at the clock edge, judges each read against the old contents and each error flag against the write of the previous cycle.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int NUM_BANKS = 6;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  // bank 0 is the base view used by user and system modes
  typedef enum logic [2:0] {
    BANK_BASE = 3'd0,
    BANK_FIQ  = 3'd1,
    BANK_IRQ  = 3'd2,
    BANK_SVC  = 3'd3,
    BANK_ABT  = 3'd4,
    BANK_UND  = 3'd5
  } bank_e;

  localparam logic [3:0] ADDR_SP = 4'd13;
  localparam logic [3:0] ADDR_LR = 4'd14;
  localparam logic [3:0] ADDR_PC = 4'd15;
endpackage

// File: rtl/bankrf_decode.sv
module bankrf_decode
  import bankrf_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o
);
  always_comb begin
    case (mode_i)
      MODE_FIQ: bank_o = BANK_FIQ;
      MODE_IRQ: bank_o = BANK_IRQ;
      MODE_SVC: bank_o = BANK_SVC;
      MODE_ABT: bank_o = BANK_ABT;
      MODE_UND: bank_o = BANK_UND;
      default:  bank_o = BANK_BASE; // user, system and unknown codes
    endcase
  end
endmodule

// File: rtl/bankrf_gpr.sv
module bankrf_gpr
  import bankrf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SHARED = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank_i,
  input  logic [3:0]        rd_addr_i [2],
  output logic [DATA_W-1:0] rd_data_o [2],
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int         SH_W      = $clog2(NUM_SHARED);
  localparam logic [3:0] SHARED_LIM = 4'(NUM_SHARED);

  logic [DATA_W-1:0] shared_q [NUM_SHARED];
  logic [DATA_W-1:0] shared_d [NUM_SHARED];
  logic [DATA_W-1:0] sp_q [NUM_BANKS];
  logic [DATA_W-1:0] sp_d [NUM_BANKS];
  logic [DATA_W-1:0] lr_q [NUM_BANKS];
  logic [DATA_W-1:0] lr_d [NUM_BANKS];
  logic [DATA_W-1:0] pc_q, pc_d;

  always_comb begin
    shared_d = shared_q;
    sp_d     = sp_q;
    lr_d     = lr_q;
    pc_d     = pc_q;
    if (wr_en_i) begin
      if (wr_addr_i < SHARED_LIM)
        shared_d[wr_addr_i[SH_W-1:0]] = wr_data_i;
      else if (wr_addr_i == ADDR_SP)
        sp_d[int'(bank_i)] = wr_data_i;
      else if (wr_addr_i == ADDR_LR)
        lr_d[int'(bank_i)] = wr_data_i;
      else if (wr_addr_i == ADDR_PC)
        pc_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SHARED; i++) shared_q[i] <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        sp_q[b] <= '0;
        lr_q[b] <= '0;
      end
      pc_q <= '0;
    end else if (wr_en_i) begin
      shared_q <= shared_d;
      sp_q     <= sp_d;
      lr_q     <= lr_d;
      pc_q     <= pc_d;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (rd_addr_i[p] < SHARED_LIM)
        rd_data_o[p] = shared_q[rd_addr_i[p][SH_W-1:0]];
      else if (rd_addr_i[p] == ADDR_SP)
        rd_data_o[p] = sp_q[int'(bank_i)];
      else if (rd_addr_i[p] == ADDR_LR)
        rd_data_o[p] = lr_q[int'(bank_i)];
      else if (rd_addr_i[p] == ADDR_PC)
        rd_data_o[p] = pc_q;
      else
        rd_data_o[p] = '0;
    end
  end
endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank_i,
  input  logic              cur_wr_en_i,
  input  logic [DATA_W-1:0] cur_wr_data_i,
  output logic [DATA_W-1:0] cur_rd_data_o,
  input  logic              sav_wr_en_i,
  input  logic [DATA_W-1:0] sav_wr_data_i,
  output logic [DATA_W-1:0] sav_rd_data_o,
  output logic              sav_err_o
);
  localparam int NUM_SAVED = NUM_BANKS - 1;
  // supervisor mode with both interrupt masks set
  localparam logic [DATA_W-1:0] CUR_RESET = DATA_W'({2'b11, 1'b0, MODE_SVC});

  logic [DATA_W-1:0] cur_q, cur_d;
  logic [DATA_W-1:0] sav_q [NUM_SAVED];
  logic [DATA_W-1:0] sav_d [NUM_SAVED];
  logic              err_q, err_d;
  logic              has_saved;
  logic              sav_en;

  assign has_saved = (bank_i != BANK_BASE);
  assign sav_en    = sav_wr_en_i && has_saved;

  always_comb begin
    cur_d = cur_wr_data_i;
    sav_d = sav_q;
    if (has_saved) sav_d[int'(bank_i) - 1] = sav_wr_data_i;
    err_d = sav_wr_en_i && !has_saved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= CUR_RESET;
    else if (cur_wr_en_i) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SAVED; i++) sav_q[i] <= '0;
    end else if (sav_en) begin
      sav_q <= sav_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cur_rd_data_o = cur_q;
  assign sav_rd_data_o = has_saved ? sav_q[int'(bank_i) - 1] : cur_q;
  assign sav_err_o     = err_q;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SHARED = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cur_wr_en_i,
  input  logic [DATA_W-1:0] cur_wr_data_i,
  output logic [DATA_W-1:0] cur_rd_data_o,
  input  logic              sav_wr_en_i,
  input  logic [DATA_W-1:0] sav_wr_data_i,
  output logic [DATA_W-1:0] sav_rd_data_o,
  output logic              sav_err_o
);
  bank_e             bank;
  logic [3:0]        rd_addr [2];
  logic [DATA_W-1:0] rd_data [2];

  assign rd_addr[0]  = rd_a_addr_i;
  assign rd_addr[1]  = rd_b_addr_i;
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  bankrf_decode u_decode (
    .mode_i (mode_i),
    .bank_o (bank)
  );

  bankrf_gpr #(
    .DATA_W     (DATA_W),
    .NUM_SHARED (NUM_SHARED)
  ) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_i    (bank),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i)
  );

  bankrf_status #(
    .DATA_W (DATA_W)
  ) u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_i        (bank),
    .cur_wr_en_i   (cur_wr_en_i),
    .cur_wr_data_i (cur_wr_data_i),
    .cur_rd_data_o (cur_rd_data_o),
    .sav_wr_en_i   (sav_wr_en_i),
    .sav_wr_data_i (sav_wr_data_i),
    .sav_rd_data_o (sav_rd_data_o),
    .sav_err_o     (sav_err_o)
  );
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic [3:0]        rd_a_addr_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_addr_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              cur_wr_en_i,
  input logic [DATA_W-1:0] cur_wr_data_i,
  input logic [DATA_W-1:0] cur_rd_data_o,
  input logic              sav_wr_en_i,
  input logic [DATA_W-1:0] sav_wr_data_i,
  input logic [DATA_W-1:0] sav_rd_data_o,
  input logic              sav_err_o
);
  logic base_mode;
  assign base_mode = !(mode_i inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011});

  // R1: a shared register written last cycle reads back the new value in any mode
  assert_shared_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en_i) && $past(wr_addr_i) < 4'd8 && rd_a_addr_i == $past(wr_addr_i))
      |-> rd_a_data_o == $past(wr_data_i));

  // R6: the current status takes the written value one edge later
  assert_cur_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr_en_i |=> cur_rd_data_o == $past(cur_wr_data_i));

  // R8: the saved-status port mirrors the current status in base modes
  assert_sav_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    base_mode |-> sav_rd_data_o == cur_rd_data_o);

  // R9: the error flag only follows a saved-status write made in a base mode
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sav_err_o |-> ($past(sav_wr_en_i) && !($past(mode_i) inside
      {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011})));

  // R9: such a write is always flagged
  assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_wr_en_i && base_mode) |=> sav_err_o);

  // R11: unmapped numbers read zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr_i inside {[4'd8:4'd12]}) |-> rd_b_data_o == '0);
endmodule

bind banked_regfile bankrf_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  ra, rb, wa;
  logic [31:0] rda, rdb, wd, cwd, crd, swd, srd;
  logic        we, cwe, swe, serr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_sh [8];
  logic [31:0] m_sp [6];
  logic [31:0] m_lr [6];
  logic [31:0] m_pc, m_cur;
  logic [31:0] m_sav [6];
  logic        m_err;

  logic [4:0] modes [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                            5'b11011, 5'b11111, 5'b00000, 5'b10101};

  always #5 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .rd_a_addr_i(ra), .rd_a_data_o(rda), .rd_b_addr_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .cur_wr_en_i(cwe), .cur_wr_data_i(cwd), .cur_rd_data_o(crd),
    .sav_wr_en_i(swe), .sav_wr_data_i(swd), .sav_rd_data_o(srd),
    .sav_err_o(serr)
  );

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [4:0] m);
    if (a < 8) return m_sh[a[2:0]];
    if (a == 13) return m_sp[bank_of(m)];
    if (a == 14) return m_lr[bank_of(m)];
    if (a == 15) return m_pc;
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic [4:0] m);
    if (a < 8) return "R1";
    if (a == 15) return "R4";
    if (a > 12) begin
      if (bank_of(m) != 0) return "R2";
      if (m == 5'b10000 || m == 5'b11111) return "R3";
      return "R5";
    end
    return "R11";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_sh[i] = 0;
    for (int b = 0; b < 6; b++) begin m_sp[b] = 0; m_lr[b] = 0; m_sav[b] = 0; end
    m_pc = 0; m_cur = 32'hD3; m_err = 0;
  endtask

  // inputs are already driven after a negedge; check reads then apply the edge
  task automatic step_check();
    #1;
    check(tag_of(ra, mode), rda, exp_rd(ra, mode));
    check(tag_of(rb, mode), rdb, exp_rd(rb, mode));
    check("R6", crd, m_cur);
    if (bank_of(mode) == 0) check("R8", srd, m_cur);
    else check("R7", srd, m_sav[bank_of(mode)]);
    check("R9", {31'b0, serr}, {31'b0, m_err});
    @(posedge clk);
    if (we) begin
      if (wa < 8) m_sh[wa[2:0]] = wd;
      else if (wa == 13) m_sp[bank_of(mode)] = wd;
      else if (wa == 14) m_lr[bank_of(mode)] = wd;
      else if (wa == 15) m_pc = wd;
    end
    if (cwe) m_cur = cwd;
    if (swe && bank_of(mode) != 0) m_sav[bank_of(mode)] = swd;
    m_err = swe && (bank_of(mode) == 0);
    @(negedge clk);
  endtask

  task automatic idle();
    we = 0; cwe = 0; swe = 0; wa = 0; wd = 0; cwd = 0; swd = 0; ra = 0; rb = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    mode = 5'b10000; idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    #1;
    check("R12", crd, 32'h000000D3);
    check("R12", {31'b0, serr}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      ra = 4'(a); mode = 5'b10011; #1;
      check("R12", rda, 32'h0);
    end
    check("R12", srd, 32'h0);
    @(negedge clk);

    // R10: same-cycle write and read on one register
    idle(); mode = 5'b10001; we = 1; wa = 13; wd = 32'hA5A5_0001; ra = 13; rb = 3;
    #1; check("R10", rda, 32'h0);
    step_check();
    idle(); mode = 5'b10001; ra = 13;
    #1; check("R10", rda, 32'hA5A5_0001);
    // R2: other exception mode sees its own copy
    mode = 5'b10010; #1; check("R2", rda, 32'h0);
    // R5: unknown code shares the user view
    idle(); mode = 5'b10000; we = 1; wa = 14; wd = 32'h1234_5678; step_check();
    idle(); mode = 5'b00000; ra = 14; #1; check("R5", rda, 32'h1234_5678);
    mode = 5'b11111; #1; check("R3", rda, 32'h1234_5678);
    step_check();
    // R9: rejected saved-status write, flag lasts exactly one cycle
    idle(); mode = 5'b11111; swe = 1; swd = 32'hDEAD_BEEF; step_check();
    idle(); mode = 5'b11111; #1; check("R9", {31'b0, serr}, 32'h1);
    check("R9", srd, crd);
    step_check();
    #1; check("R9", {31'b0, serr}, 32'h0);
    // R11: write to unmapped number has no effect
    idle(); we = 1; wa = 9; wd = 32'hFFFF_FFFF; step_check();
    idle(); ra = 9; rb = 9; step_check();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      mode = modes[$urandom_range(8)];
      ra = 4'($urandom_range(15)); rb = 4'($urandom_range(15));
      we = 1'($urandom_range(1)); wa = 4'($urandom_range(15)); wd = $urandom;
      cwe = ($urandom_range(7) == 0); cwd = $urandom;
      swe = ($urandom_range(3) == 0); swd = $urandom;
      if ($urandom_range(3) == 0) ra = wa;
      step_check();
    end
    idle(); step_check();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule